// File: doc/BRIEF.md
# Dual-Bank GPIO Controller with Radio-State Output Selection

This block controls two 16-pin I/O groups, a receive-side bank and a transmit-side bank, from a 16-bit register bus. For each pin it keeps four bits of configuration: an output enable, a software output value, a source-select bit and a debug-mode bit. The two configuration bits of a pin pick where its driven value comes from. The choices are the software value, a value chosen by the radio's current activity, or one of two debug buses from the surrounding fabric.

The radio activity arrives as two flags, `tx_active` and `rx_active`. A small state machine registers them into one of four states: IDLE, TX-ONLY, RX-ONLY and FULL-DUPLEX. A bank of eight 16-bit registers holds one receive-bank value and one transmit-bank value for each state. While the state machine sits in a state, every pin in automatic mode takes its value from the register that belongs to that state and to the pin's bank. The state machine can move from any state to any other in one clock. The transitions are named START-TX, START-RX, START-BOTH, DROP-TX, DROP-RX, DROP-BOTH, SWAP-TO-TX and SWAP-TO-RX, and HOLD covers the case where the state does not change.

Top module: `gpio_atr_ctrl`

## Requirements
- R1: After reset every register reads 0, every `*_pad_oe` bit is 0 and every `*_pad_out` bit is 0.
- R2: A bit set to 1 in a direction register (byte address 4 for the receive bank, 6 for the transmit bank) sets the matching `*_pad_oe` bit in the cycle after the write. Writing 0 releases the pin. Direction registers read back the written value.
- R3: A pin with debug-mode 0 and select 0 drives the software value last written at byte address 0 (receive bank) or 2 (transmit bank).
- R4: A pin with debug-mode 0 and select 1 drives its bank's value for the current radio state. The state bank sits at byte addresses 16 to 30. In order these hold IDLE-rx, IDLE-tx, TXONLY-rx, TXONLY-tx, RXONLY-rx, RXONLY-tx, FULL-rx and FULL-tx, each 2 apart.
- R5: A pin with debug-mode 1 (registers at byte address 12 for rx, 14 for tx) and select 0 (registers at 8 for rx, 10 for tx) drives its bank's debug bus 0.
- R6: A pin with debug-mode 1 and select 1 drives its bank's debug bus 1.
- R7: The radio state is IDLE when neither flag is set, TX-ONLY when only `tx_active` is set, RX-ONLY when only `rx_active` is set and FULL-DUPLEX when both are set. It follows a flag change one clock edge later.
- R8: Byte address bit 0 is ignored, so an odd address reaches the same register as the even address below it.
- R9: Reading byte address 0 or 2 returns that bank's pad inputs as sampled on the previous clock edge, not the software value.
- R10: A write to one bank's registers leaves the other bank's outputs and enables unchanged.
- R11: A pin whose direction bit is 0 drives 0 on `*_pad_out`, whatever its source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 5 | Byte address; bit 4 selects the state bank, bit 0 ignored |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| tx_active | input | 1 | Radio transmitting |
| rx_active | input | 1 | Radio receiving |
| rx_pad_in | input | 16 | Receive-bank pad inputs |
| rx_pad_out | output | 16 | Receive-bank driven values |
| rx_pad_oe | output | 16 | Receive-bank output enables |
| tx_pad_in | input | 16 | Transmit-bank pad inputs |
| tx_pad_out | output | 16 | Transmit-bank driven values |
| tx_pad_oe | output | 16 | Transmit-bank output enables |
| rx_dbg0 | input | 16 | Receive-bank debug bus 0 |
| rx_dbg1 | input | 16 | Receive-bank debug bus 1 |
| tx_dbg0 | input | 16 | Transmit-bank debug bus 0 |
| tx_dbg1 | input | 16 | Transmit-bank debug bus 1 |

## Verification
A stale or wrong radio state shows up on the pins one edge after the flags change: every automatic-mode output carries the wrong state register. The bench therefore checks each of the four states on both banks, and also confirms that nothing moves before that edge. A corrupted configuration bit is visible on that same pin's output or enable in the cycle after the write. The bench varies select and debug-mode pin by pin, so a swapped source or a crossed bank appears on specific bits. Bad capture of the pad inputs appears on the next read of the IO address.

// File: rtl/gpio_atr_pkg.sv
package gpio_atr_pkg;

    // Radio activity state; encoding doubles as the upper index into the state bank
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TXON = 2'd1,
        ST_RXON = 2'd2,
        ST_FULL = 2'd3
    } radio_state_t;

    // Pin-control register index (byte address bits 3:1 when bit 4 is clear)
    typedef enum logic [2:0] {
        REG_RX_IO   = 3'd0,
        REG_TX_IO   = 3'd1,
        REG_RX_DIR  = 3'd2,
        REG_TX_DIR  = 3'd3,
        REG_RX_SRC  = 3'd4,
        REG_TX_SRC  = 3'd5,
        REG_RX_DBGM = 3'd6,
        REG_TX_DBGM = 3'd7
    } pin_reg_t;

    typedef enum logic [1:0] {
        SRC_SW   = 2'd0,
        SRC_AUTO = 2'd1,
        SRC_DBG0 = 2'd2,
        SRC_DBG1 = 2'd3
    } pin_src_t;

    function automatic pin_src_t decode_src(input logic dbg_mode, input logic sel);
        return pin_src_t'({dbg_mode, sel});
    endfunction

endpackage

// File: rtl/gpio_atr_state.sv
module gpio_atr_state
    import gpio_atr_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tx_active,
    input  logic         rx_active,
    output radio_state_t state
);

    radio_state_t state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state: every state reaches every other in one edge
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (tx_active && rx_active) state_d = ST_FULL;      // START-BOTH
                else if (tx_active)         state_d = ST_TXON;      // START-TX
                else if (rx_active)         state_d = ST_RXON;      // START-RX
                else                        state_d = ST_IDLE;      // HOLD
            end
            ST_TXON: begin
                if (tx_active && rx_active) state_d = ST_FULL;      // START-RX on top
                else if (tx_active)         state_d = ST_TXON;      // HOLD
                else if (rx_active)         state_d = ST_RXON;      // SWAP-TO-RX
                else                        state_d = ST_IDLE;      // DROP-TX
            end
            ST_RXON: begin
                if (tx_active && rx_active) state_d = ST_FULL;      // START-TX on top
                else if (tx_active)         state_d = ST_TXON;      // SWAP-TO-TX
                else if (rx_active)         state_d = ST_RXON;      // HOLD
                else                        state_d = ST_IDLE;      // DROP-RX
            end
            ST_FULL: begin
                if (tx_active && rx_active) state_d = ST_FULL;      // HOLD
                else if (tx_active)         state_d = ST_TXON;      // DROP-RX
                else if (rx_active)         state_d = ST_RXON;      // DROP-TX
                else                        state_d = ST_IDLE;      // DROP-BOTH
            end
            default:                        state_d = ST_IDLE;
        endcase
    end

    // Output process
    always_comb begin
        state = state_q;
    end

    p_full_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && rx_active) |=> (state == ST_FULL));
    p_idle_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_active && !rx_active) |=> (state == ST_IDLE));
    p_txon_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && !rx_active) |=> (state == ST_TXON));

endmodule

// File: rtl/gpio_atr_regs.sv
module gpio_atr_regs
    import gpio_atr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    output logic [DATA_W-1:0]            rdata,
    input  logic [DATA_W-1:0]            rx_pad_in,
    input  logic [DATA_W-1:0]            tx_pad_in,
    output logic [DATA_W-1:0]            rx_sw,
    output logic [DATA_W-1:0]            tx_sw,
    output logic [DATA_W-1:0]            rx_dir,
    output logic [DATA_W-1:0]            tx_dir,
    output logic [DATA_W-1:0]            rx_sel,
    output logic [DATA_W-1:0]            tx_sel,
    output logic [DATA_W-1:0]            rx_dbgm,
    output logic [DATA_W-1:0]            tx_dbgm,
    output logic [7:0][DATA_W-1:0]       auto_bank
);

    localparam int IDX_W   = 3;
    localparam int BANK_BIT = IDX_W + 1;

    logic [IDX_W-1:0] idx;
    logic             bank_sel;
    logic             unused_addr_bits;

    assign idx      = addr[IDX_W:1];
    assign bank_sel = addr[BANK_BIT];

    if (ADDR_W > BANK_BIT + 1) begin : g_hi_unused
        assign unused_addr_bits = addr[0] ^ (|addr[ADDR_W-1:BANK_BIT+1]);
    end else begin : g_hi_none
        assign unused_addr_bits = addr[0];
    end

    logic [DATA_W-1:0] rx_sw_q, tx_sw_q, rx_dir_q, tx_dir_q;
    logic [DATA_W-1:0] rx_sel_q, tx_sel_q, rx_dbgm_q, tx_dbgm_q;
    logic [DATA_W-1:0] rx_smp_q, tx_smp_q;
    logic [7:0][DATA_W-1:0] bank_q;

    // Pad input capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_smp_q <= '0;
            tx_smp_q <= '0;
        end else begin
            rx_smp_q <= rx_pad_in;
            tx_smp_q <= tx_pad_in;
        end
    end

    // Pin-control registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sw_q   <= '0;
            tx_sw_q   <= '0;
            rx_dir_q  <= '0;
            tx_dir_q  <= '0;
            rx_sel_q  <= '0;
            tx_sel_q  <= '0;
            rx_dbgm_q <= '0;
            tx_dbgm_q <= '0;
        end else if (wr_en && !bank_sel) begin
            unique case (pin_reg_t'(idx))
                REG_RX_IO:   rx_sw_q   <= wdata;
                REG_TX_IO:   tx_sw_q   <= wdata;
                REG_RX_DIR:  rx_dir_q  <= wdata;
                REG_TX_DIR:  tx_dir_q  <= wdata;
                REG_RX_SRC:  rx_sel_q  <= wdata;
                REG_TX_SRC:  tx_sel_q  <= wdata;
                REG_RX_DBGM: rx_dbgm_q <= wdata;
                REG_TX_DBGM: tx_dbgm_q <= wdata;
                default: ;
            endcase
        end
    end

    // Per-state value bank
    for (genvar k = 0; k < 8; k++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n)                                   bank_q[k] <= '0;
            else if (wr_en && bank_sel && idx == IDX_W'(k)) bank_q[k] <= wdata;
        end
    end

    // Read mux
    always_comb begin
        rdata = '0;
        if (bank_sel) begin
            rdata = bank_q[idx];
        end else begin
            unique case (pin_reg_t'(idx))
                REG_RX_IO:   rdata = rx_smp_q;
                REG_TX_IO:   rdata = tx_smp_q;
                REG_RX_DIR:  rdata = rx_dir_q;
                REG_TX_DIR:  rdata = tx_dir_q;
                REG_RX_SRC:  rdata = rx_sel_q;
                REG_TX_SRC:  rdata = tx_sel_q;
                REG_RX_DBGM: rdata = rx_dbgm_q;
                REG_TX_DBGM: rdata = tx_dbgm_q;
                default:     rdata = '0;
            endcase
        end
    end

    assign rx_sw     = rx_sw_q;
    assign tx_sw     = tx_sw_q;
    assign rx_dir    = rx_dir_q;
    assign tx_dir    = tx_dir_q;
    assign rx_sel    = rx_sel_q;
    assign tx_sel    = tx_sel_q;
    assign rx_dbgm   = rx_dbgm_q;
    assign tx_dbgm   = tx_dbgm_q;
    assign auto_bank = bank_q;

    p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !bank_sel && idx == 3'd2) |=> (rx_dir == $past(wdata)));
    p_sample_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rx_smp_q == $past(rx_pad_in)));
    p_bank_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !bank_sel && !idx[0]) |=> $stable(tx_dir) && $stable(tx_sw));

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
    import gpio_atr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] dir,
    input  logic [DATA_W-1:0] sw_val,
    input  logic [DATA_W-1:0] auto_val,
    input  logic [DATA_W-1:0] dbg0,
    input  logic [DATA_W-1:0] dbg1,
    input  logic [DATA_W-1:0] sel,
    input  logic [DATA_W-1:0] dbgm,
    output logic [DATA_W-1:0] pad_out,
    output logic [DATA_W-1:0] pad_oe
);

    for (genvar p = 0; p < DATA_W; p++) begin : g_pin
        logic drv;
        always_comb begin
            drv = 1'b0;
            unique case (decode_src(dbgm[p], sel[p]))
                SRC_SW:   drv = sw_val[p];
                SRC_AUTO: drv = auto_val[p];
                SRC_DBG0: drv = dbg0[p];
                SRC_DBG1: drv = dbg1[p];
                default:  drv = 1'b0;
            endcase
        end
        assign pad_out[p] = dir[p] & drv;
        assign pad_oe[p]  = dir[p];
    end

endmodule

// File: rtl/gpio_atr_ctrl.sv
module gpio_atr_ctrl
    import gpio_atr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tx_active,
    input  logic              rx_active,
    input  logic [DATA_W-1:0] rx_pad_in,
    output logic [DATA_W-1:0] rx_pad_out,
    output logic [DATA_W-1:0] rx_pad_oe,
    input  logic [DATA_W-1:0] tx_pad_in,
    output logic [DATA_W-1:0] tx_pad_out,
    output logic [DATA_W-1:0] tx_pad_oe,
    input  logic [DATA_W-1:0] rx_dbg0,
    input  logic [DATA_W-1:0] rx_dbg1,
    input  logic [DATA_W-1:0] tx_dbg0,
    input  logic [DATA_W-1:0] tx_dbg1
);

    radio_state_t           state;
    logic [DATA_W-1:0]      rx_sw, tx_sw, rx_dir, tx_dir;
    logic [DATA_W-1:0]      rx_sel, tx_sel, rx_dbgm, tx_dbgm;
    logic [7:0][DATA_W-1:0] auto_bank;
    logic [DATA_W-1:0]      rx_auto, tx_auto;

    gpio_atr_state u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_active (tx_active),
        .rx_active (rx_active),
        .state     (state)
    );

    gpio_atr_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .rdata     (bus_rdata),
        .rx_pad_in (rx_pad_in),
        .tx_pad_in (tx_pad_in),
        .rx_sw     (rx_sw),
        .tx_sw     (tx_sw),
        .rx_dir    (rx_dir),
        .tx_dir    (tx_dir),
        .rx_sel    (rx_sel),
        .tx_sel    (tx_sel),
        .rx_dbgm   (rx_dbgm),
        .tx_dbgm   (tx_dbgm),
        .auto_bank (auto_bank)
    );

    // State selects the pair; bank bit 0 selects rx (0) or tx (1)
    assign rx_auto = auto_bank[{state, 1'b0}];
    assign tx_auto = auto_bank[{state, 1'b1}];

    gpio_pin_mux #(.DATA_W(DATA_W)) u_rx_mux (
        .dir      (rx_dir),
        .sw_val   (rx_sw),
        .auto_val (rx_auto),
        .dbg0     (rx_dbg0),
        .dbg1     (rx_dbg1),
        .sel      (rx_sel),
        .dbgm     (rx_dbgm),
        .pad_out  (rx_pad_out),
        .pad_oe   (rx_pad_oe)
    );

    gpio_pin_mux #(.DATA_W(DATA_W)) u_tx_mux (
        .dir      (tx_dir),
        .sw_val   (tx_sw),
        .auto_val (tx_auto),
        .dbg0     (tx_dbg0),
        .dbg1     (tx_dbg1),
        .sel      (tx_sel),
        .dbgm     (tx_dbgm),
        .pad_out  (tx_pad_out),
        .pad_oe   (tx_pad_oe)
    );

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (rx_pad_oe == '0 && tx_pad_oe == '0));
    p_input_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_pad_out & ~rx_dir) == '0) && ((tx_pad_out & ~tx_dir) == '0));
    p_sw_route_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_pad_out ^ rx_sw) & rx_dir & ~rx_dbgm & ~rx_sel) == '0);
    p_auto_route_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_pad_out ^ tx_auto) & tx_dir & ~tx_dbgm & tx_sel) == '0);
    p_dbg0_route_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_pad_out ^ rx_dbg0) & rx_dir & rx_dbgm & ~rx_sel) == '0);
    p_dbg1_route_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_pad_out ^ tx_dbg1) & tx_dir & tx_dbgm & tx_sel) == '0);

endmodule

// File: tb/tb_gpio_atr_ctrl.sv
module tb_gpio_atr_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        tx_active = 1'b0;
    logic        rx_active = 1'b0;
    logic [15:0] rx_pad_in = '0, tx_pad_in = '0;
    logic [15:0] rx_pad_out, rx_pad_oe, tx_pad_out, tx_pad_oe;
    logic [15:0] rx_dbg0 = '0, rx_dbg1 = '0, tx_dbg0 = '0, tx_dbg1 = '0;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    gpio_atr_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_active(tx_active), .rx_active(rx_active),
        .rx_pad_in(rx_pad_in), .rx_pad_out(rx_pad_out), .rx_pad_oe(rx_pad_oe),
        .tx_pad_in(tx_pad_in), .tx_pad_out(tx_pad_out), .tx_pad_oe(tx_pad_oe),
        .rx_dbg0(rx_dbg0), .rx_dbg1(rx_dbg1), .tx_dbg0(tx_dbg0), .tx_dbg1(tx_dbg1)
    );

    // Byte addresses
    localparam logic [4:0] A_RX_IO = 5'd0,  A_TX_IO = 5'd2;
    localparam logic [4:0] A_RX_DIR = 5'd4, A_TX_DIR = 5'd6;
    localparam logic [4:0] A_RX_SEL = 5'd8, A_TX_SEL = 5'd10;
    localparam logic [4:0] A_RX_DBG = 5'd12, A_TX_DBG = 5'd14;

    function automatic logic [15:0] bank_val(input int k);
        return 16'h3c00 + 16'(k) * 16'h0513;
    endfunction

    function automatic logic [15:0] ref_pins(input logic [15:0] dir, sw, au, d0, d1, sel, dbgm);
        logic [15:0] r;
        for (int p = 0; p < 16; p++) begin
            if (!dir[p])      r[p] = 1'b0;
            else if (dbgm[p]) r[p] = sel[p] ? d1[p] : d0[p];
            else              r[p] = sel[p] ? au[p] : sw[p];
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        chk("R1 rx_oe", rx_pad_oe, 16'h0);
        chk("R1 tx_oe", tx_pad_oe, 16'h0);
        chk("R1 rx_out", rx_pad_out, 16'h0);
        chk("R1 tx_out", tx_pad_out, 16'h0);
        rd(A_TX_DIR, v); chk("R1 tx_dir read", v, 16'h0);
        rd(5'd30, v);    chk("R1 bank read", v, 16'h0);
    endtask

    task automatic t_software;
        logic [15:0] v;
        wr(A_RX_DIR, 16'hffff);
        wr(A_RX_IO, 16'ha5c3);
        chk("R3 rx sw drive", rx_pad_out, 16'ha5c3);
        chk("R10 tx untouched out", tx_pad_out, 16'h0);
        chk("R10 tx untouched oe", tx_pad_oe, 16'h0);
        wr(A_TX_DIR | 5'd1, 16'h00ff);
        chk("R8 odd address dir", tx_pad_oe, 16'h00ff);
        rd(A_TX_DIR, v); chk("R2 dir readback", v, 16'h00ff);
        rd(A_TX_DIR | 5'd1, v); chk("R8 odd address read", v, 16'h00ff);
        wr(A_TX_IO, 16'h5a5a);
        chk("R11 masked by dir", tx_pad_out, 16'h005a);
        chk("R10 rx kept", rx_pad_out, 16'ha5c3);
    endtask

    task automatic t_sample;
        logic [15:0] v;
        @(negedge clk);
        rx_pad_in = 16'h1357; tx_pad_in = 16'hbeef;
        rd(A_RX_IO, v); chk("R9 before edge", v, 16'h0);
        @(negedge clk);
        rd(A_RX_IO, v); chk("R9 rx sampled", v, 16'h1357);
        rd(A_TX_IO, v); chk("R9 tx sampled", v, 16'hbeef);
    endtask

    task automatic t_state_walk;
        logic [1:0] seq [5];
        seq[0] = 2'b01; seq[1] = 2'b11; seq[2] = 2'b10; seq[3] = 2'b01; seq[4] = 2'b00;
        for (int k = 0; k < 8; k++) wr(5'd16 + 5'(2 * k), bank_val(k));
        wr(A_RX_DIR, 16'hffff); wr(A_TX_DIR, 16'hffff);
        wr(A_RX_SEL, 16'hffff); wr(A_TX_SEL, 16'hffff);
        chk("R4 idle rx", rx_pad_out, bank_val(0));
        chk("R4 idle tx", tx_pad_out, bank_val(1));
        for (int i = 0; i < 5; i++) begin
            int s, prev;
            // seq bits {rx,tx}; state code tx=1, rx=2
            s = (seq[i][0] ? 1 : 0) + (seq[i][1] ? 2 : 0);
            prev = (i == 0) ? 0 : (seq[i-1][0] ? 1 : 0) + (seq[i-1][1] ? 2 : 0);
            @(negedge clk);
            tx_active = seq[i][0]; rx_active = seq[i][1];
            #1;
            chk("R7 no early change", rx_pad_out, bank_val(2 * prev));
            @(negedge clk);
            chk("R7/R4 rx state value", rx_pad_out, bank_val(2 * s));
            chk("R7/R4 tx state value", tx_pad_out, bank_val(2 * s + 1));
        end
    endtask

    task automatic t_debug;
        logic [15:0] au;
        rx_dbg0 = 16'h1234; rx_dbg1 = 16'hfedc;
        tx_dbg0 = 16'h0f0f; tx_dbg1 = 16'h6996;
        wr(A_RX_DBG, 16'hffff);
        wr(A_RX_SEL, 16'h0f0f);
        chk("R5/R6 rx debug mix", rx_pad_out, (16'hfedc & 16'h0f0f) | (16'h1234 & 16'hf0f0));
        wr(A_RX_SEL, 16'h0000);
        chk("R5 rx debug bus 0", rx_pad_out, 16'h1234);
        wr(A_RX_SEL, 16'hffff);
        chk("R6 rx debug bus 1", rx_pad_out, 16'hfedc);
        wr(A_TX_IO, 16'haaaa);
        wr(A_TX_DBG, 16'h00ff);
        wr(A_TX_SEL, 16'h0ff0);
        au = bank_val(1);
        chk("R3/R4/R5/R6 tx per-pin mix", tx_pad_out,
            ref_pins(16'hffff, 16'haaaa, au, 16'h0f0f, 16'h6996, 16'h0ff0, 16'h00ff));
    endtask

    task automatic t_release;
        wr(A_RX_DIR, 16'h0000);
        wr(A_TX_DIR, 16'h0000);
        chk("R2 rx released", rx_pad_oe, 16'h0);
        chk("R2 tx released", tx_pad_oe, 16'h0);
        chk("R11 rx quiet", rx_pad_out, 16'h0);
        chk("R11 tx quiet", tx_pad_out, 16'h0);
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_software;
        t_sample;
        t_state_walk;
        t_debug;
        t_release;
        finished = 1;
        summary;
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            summary;
        end
    end

endmodule